// File: doc/BRIEF.md
# Flash Image Programming Sequencer

This block writes a complete memory image into an on-chip flash array without processor involvement. After a start pulse it fetches the 16-bit word stored at flash address 0. That word is the reset vector. If the word is anything other than all ones, the block first commands a whole-array erase. It then streams source bytes into the flash. The flash controller sees only three things: bit-set writes to its control register, a status read whose bit 0 means busy, and a data-write strobe carrying a window index, an in-window offset and a byte.

The target address space is cut into windows of `WIN_BYTES` bytes. The offset counts up inside a window. When it passes the last byte of the window it returns to zero and the window index steps by one, so source and target stay in lockstep. There are two programming styles, chosen by a mode input that is captured at start:
- **Page style:** one command programs a burst of `BURST` bytes.
- **Byte style:** one command programs a single byte. This suits a slow incoming stream.

Before each erase or program command, the block waits until the controller is idle. When the whole image has been written and the last operation has finished, the block raises a completion pulse and a software-reset request together.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and afterwards until a start pulse, the outputs `src_ready_o`, `vec_rd_o`, `ctrl_wr_o`, `fl_wr_o`, `done_o` and `sreset_o` are all low.
- R2: A start pulse causes one read of the word at flash address 0, and `vec_word_i` is sampled one cycle later. If that word equals 0xFFFF, no erase command is issued and programming starts directly.
- R3: If the word at address 0 is not 0xFFFF, the block issues the erase sequence before any data write. The sequence is control-set value 0x20 followed by control-set value 0x80 (write start).
- R4: No control command and no data write is issued in any cycle where `ctrl_stat_i` bit 0 (busy) is 1. Before each erase or program command, the block waits until that bit reads 0.
- R5: In page style (`byte_mode_i`=0 at start), each program operation has three steps in order: control-set 0x40, exactly `BURST` data writes, control-set 0x80.
- R6: In byte style (`byte_mode_i`=1 at start), each operation has three steps in order: control-set 0x10, exactly one data write, control-set 0x80. `src_ready_o` rises once for each byte it is ready to accept.
- R7: Data write k of a run (counting from 0) targets window k / `WIN_BYTES` and offset k mod `WIN_BYTES`. When the offset wraps to 0, the window index increments.
- R8: A run writes exactly `IMAGE_BYTES` bytes, in source order, with the final window partly filled. `IMAGE_BYTES` must be a multiple of `BURST`.
- R9: After the final write-start command, and once busy has returned to 0, `done_o` pulses high for exactly one cycle. `sreset_o` is high in that same cycle.
- R10: A source byte is consumed only in a cycle where `src_valid_i` and `src_ready_o` are both high. Gaps in `src_valid_i` stall the sequence without skipping or repeating any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a programming run (accepted when idle) |
| byte_mode_i | input | 1 | 1 = one byte per command, 0 = page bursts; sampled at start |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Sequencer can take a source byte this cycle |
| vec_rd_o | output | 1 | Request read of the word at flash address 0 |
| vec_word_i | input | 16 | Word at address 0, valid the cycle after the request |
| ctrl_wr_o | output | 1 | Control-register bit-set strobe |
| ctrl_set_o | output | 8 | Bits to set in the control register |
| ctrl_stat_i | input | 8 | Control/status read; bit 0 = busy |
| fl_wr_o | output | 1 | Flash data-write strobe |
| fl_win_o | output | WIN_W | Target window index |
| fl_off_o | output | OFF_W | Target offset within the window |
| fl_data_o | output | 8 | Byte to program |
| done_o | output | 1 | One-cycle completion pulse |
| sreset_o | output | 1 | Software-reset request, high together with done |

## Verification
Several properties are checked on every cycle:
- no command or data write is issued while busy is set;
- each write lands at the next address in window/offset order;
- the number of writes between a mode command and its write start matches the style;
- no erase is issued once programming has begun;
- `done_o` never lasts longer than one cycle.

Other behaviours need the bench's scenarios against its flash model:
- whether the erase is skipped or taken, which depends on the vector word;
- that the final array contents equal the image;
- that stalls in the source stream lose no byte;
- that completion is signalled exactly once per run.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VEC_REQ,
    S_VEC_CHK,
    S_WAIT_E,
    S_ERASE_MODE,
    S_ERASE_GO,
    S_WAIT_P,
    S_PROG_MODE,
    S_XFER,
    S_PROG_GO,
    S_WAIT_END,
    S_FINISH
  } seq_state_t;

  localparam logic [7:0]  CMD_BYTE   = 8'h10;
  localparam logic [7:0]  CMD_ERASE  = 8'h20;
  localparam logic [7:0]  CMD_PAGE   = 8'h40;
  localparam logic [7:0]  CMD_GO     = 8'h80;
  localparam logic [15:0] BLANK_WORD = 16'hFFFF;

  // An unprogrammed reset vector reads as all ones.
  function automatic logic vec_is_blank(input logic [15:0] w);
    return w == BLANK_WORD;
  endfunction

  // The mode command that opens a program operation.
  function automatic logic [7:0] prog_cmd(input logic single);
    return single ? CMD_BYTE : CMD_PAGE;
  endfunction

endpackage

// File: rtl/fps_addr_gen.sv
module fps_addr_gen #(
  parameter int WIN_BYTES   = 16384,
  parameter int IMAGE_BYTES = 61440,
  parameter int OFF_W       = 14,
  parameter int WIN_W       = 2,
  localparam int CNT_W      = $clog2(IMAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [WIN_W-1:0] win_o,
  output logic [OFF_W-1:0] off_o,
  output logic             last_byte_o,
  output logic             win_wrap_o
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WIN_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic off_at_end(input logic [OFF_W-1:0] off);
    return off == LAST_OFF;
  endfunction

  assign last_byte_o = (cnt_q == CNT_W'(IMAGE_BYTES - 1));
  assign win_wrap_o  = step_i && off_at_end(off_o);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cnt_q <= '0;
      off_o <= '0;
      win_o <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (off_at_end(off_o)) begin
        off_o <= '0;
        win_o <= win_o + 1'b1;
      end else begin
        off_o <= off_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int BURST   = 16,
  localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        byte_mode_i,
  input  logic        src_valid_i,
  input  logic        busy_i,
  input  logic        last_byte_i,
  input  logic [15:0] vec_word_i,
  output logic        src_ready_o,
  output logic        vec_rd_o,
  output logic        ctrl_wr_o,
  output logic [7:0]  ctrl_set_o,
  output logic        take_o,
  output logic        clear_o,
  output logic        done_o
);

  seq_state_t        state_q, state_d;
  logic              mode_q;
  logic              img_end_q;
  logic [BEAT_W-1:0] beat_q;
  logic              op_end;

  assign op_end = take_o && (mode_q || beat_q == BEAT_W'(BURST - 1));

  always_comb begin
    state_d     = state_q;
    src_ready_o = 1'b0;
    vec_rd_o    = 1'b0;
    ctrl_wr_o   = 1'b0;
    ctrl_set_o  = 8'h00;
    take_o      = 1'b0;
    clear_o     = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        clear_o = 1'b1;
        state_d = S_VEC_REQ;
      end
      S_VEC_REQ: begin
        vec_rd_o = 1'b1;
        state_d  = S_VEC_CHK;
      end
      S_VEC_CHK:  state_d = vec_is_blank(vec_word_i) ? S_WAIT_P : S_WAIT_E;
      S_WAIT_E:   if (!busy_i) state_d = S_ERASE_MODE;
      S_ERASE_MODE: begin
        ctrl_wr_o  = 1'b1;
        ctrl_set_o = CMD_ERASE;
        state_d    = S_ERASE_GO;
      end
      S_ERASE_GO: begin
        ctrl_wr_o  = 1'b1;
        ctrl_set_o = CMD_GO;
        state_d    = S_WAIT_P;
      end
      S_WAIT_P:   if (!busy_i) state_d = S_PROG_MODE;
      S_PROG_MODE: begin
        ctrl_wr_o  = 1'b1;
        ctrl_set_o = prog_cmd(mode_q);
        state_d    = S_XFER;
      end
      S_XFER: begin
        src_ready_o = 1'b1;
        take_o      = src_valid_i;
        if (op_end) state_d = S_PROG_GO;
      end
      S_PROG_GO: begin
        ctrl_wr_o  = 1'b1;
        ctrl_set_o = CMD_GO;
        state_d    = img_end_q ? S_WAIT_END : S_WAIT_P;
      end
      S_WAIT_END: if (!busy_i) state_d = S_FINISH;
      S_FINISH: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      mode_q    <= 1'b0;
      img_end_q <= 1'b0;
      beat_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        mode_q    <= byte_mode_i;
        img_end_q <= 1'b0;
      end
      if (state_q == S_PROG_MODE) beat_q <= '0;
      if (take_o) begin
        beat_q <= beat_q + 1'b1;
        if (last_byte_i) img_end_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int BURST       = 16,
  parameter int WIN_BYTES   = 16384,
  parameter int IMAGE_BYTES = 61440,
  localparam int OFF_W      = $clog2(WIN_BYTES),
  localparam int NWIN       = (IMAGE_BYTES + WIN_BYTES - 1) / WIN_BYTES,
  localparam int WIN_W      = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_mode_i,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  output logic             src_ready_o,
  output logic             vec_rd_o,
  input  logic [15:0]      vec_word_i,
  output logic             ctrl_wr_o,
  output logic [7:0]       ctrl_set_o,
  input  logic [7:0]       ctrl_stat_i,
  output logic             fl_wr_o,
  output logic [WIN_W-1:0] fl_win_o,
  output logic [OFF_W-1:0] fl_off_o,
  output logic [7:0]       fl_data_o,
  output logic             done_o,
  output logic             sreset_o
);

  // Named internal events, visible to the bound checker.
  logic flash_busy;
  logic take_byte;
  logic addr_clear;
  logic last_byte;
  logic win_wrap;
  logic unused_stat;

  assign flash_busy  = ctrl_stat_i[0];
  assign unused_stat = ^ctrl_stat_i[7:1];

  fps_ctrl #(.BURST(BURST)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_mode_i (byte_mode_i),
    .src_valid_i (src_valid_i),
    .busy_i      (flash_busy),
    .last_byte_i (last_byte),
    .vec_word_i  (vec_word_i),
    .src_ready_o (src_ready_o),
    .vec_rd_o    (vec_rd_o),
    .ctrl_wr_o   (ctrl_wr_o),
    .ctrl_set_o  (ctrl_set_o),
    .take_o      (take_byte),
    .clear_o     (addr_clear),
    .done_o      (done_o)
  );

  fps_addr_gen #(
    .WIN_BYTES   (WIN_BYTES),
    .IMAGE_BYTES (IMAGE_BYTES),
    .OFF_W       (OFF_W),
    .WIN_W       (WIN_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (addr_clear),
    .step_i      (take_byte),
    .win_o       (fl_win_o),
    .off_o       (fl_off_o),
    .last_byte_o (last_byte),
    .win_wrap_o  (win_wrap)
  );

  assign fl_wr_o   = take_byte;
  assign fl_data_o = src_data_i;
  assign sreset_o  = done_o;

endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int BURST     = 16,
  parameter int WIN_BYTES = 16384,
  parameter int OFF_W     = 14,
  parameter int WIN_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vec_rd_o,
  input logic             ctrl_wr_o,
  input logic [7:0]       ctrl_set_o,
  input logic [7:0]       ctrl_stat_i,
  input logic             fl_wr_o,
  input logic [WIN_W-1:0] fl_win_o,
  input logic [OFF_W-1:0] fl_off_o,
  input logic             done_o
);

  localparam int CW = $clog2(BURST + 1) + 1;

  logic [7:0]       op_kind;
  logic [CW-1:0]    op_cnt;
  logic             prog_seen;
  logic [WIN_W-1:0] exp_win;
  logic [OFF_W-1:0] exp_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_kind   <= 8'h00;
      op_cnt    <= '0;
      prog_seen <= 1'b0;
      exp_win   <= '0;
      exp_off   <= '0;
    end else begin
      if (ctrl_wr_o && ctrl_set_o != CMD_GO) begin
        op_kind <= ctrl_set_o;
        op_cnt  <= '0;
      end else if (fl_wr_o) begin
        op_cnt <= op_cnt + 1'b1;
      end
      if (vec_rd_o) begin
        prog_seen <= 1'b0;
        exp_win   <= '0;
        exp_off   <= '0;
      end else if (fl_wr_o) begin
        prog_seen <= 1'b1;
        if (exp_off == OFF_W'(WIN_BYTES - 1)) begin
          exp_off <= '0;
          exp_win <= exp_win + 1'b1;
        end else begin
          exp_off <= exp_off + 1'b1;
        end
      end
    end
  end

  // R4
  wr_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr_o |-> !ctrl_stat_i[0]) else $error("data write while busy");

  // R4
  cmd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |-> !ctrl_stat_i[0]) else $error("command while busy");

  // R5
  page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_o && ctrl_set_o == CMD_GO && op_kind == CMD_PAGE) |-> (op_cnt == CW'(BURST)))
    else $error("page burst length wrong");

  // R6
  byte_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_o && ctrl_set_o == CMD_GO && op_kind == CMD_BYTE) |-> (op_cnt == CW'(1)))
    else $error("byte operation length wrong");

  // R7
  addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr_o |-> (fl_win_o == exp_win && fl_off_o == exp_off)) else $error("address out of order");

  // R3
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_o && ctrl_set_o == CMD_ERASE) |-> !prog_seen) else $error("erase after programming");

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle");

endmodule

bind flash_prog_seq fps_checker #(
  .BURST     (BURST),
  .WIN_BYTES (WIN_BYTES),
  .OFF_W     (OFF_W),
  .WIN_W     (WIN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vec_rd_o    (vec_rd_o),
  .ctrl_wr_o   (ctrl_wr_o),
  .ctrl_set_o  (ctrl_set_o),
  .ctrl_stat_i (ctrl_stat_i),
  .fl_wr_o     (fl_wr_o),
  .fl_win_o    (fl_win_o),
  .fl_off_o    (fl_off_o),
  .done_o      (done_o)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

  localparam int BURST    = 16;
  localparam int WIN      = 64;
  localparam int IMG      = 224;
  localparam int OFF_W    = 6;
  localparam int WIN_W    = 2;
  localparam int BUSY_CYC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_mode = 1'b0, src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_ready_o, vec_rd_o, ctrl_wr_o, fl_wr_o, done_o, sreset_o;
  logic [7:0] ctrl_set_o, fl_data_o, ctrl_stat;
  logic [15:0] vec_q;
  logic [WIN_W-1:0] fl_win_o;
  logic [OFF_W-1:0] fl_off_o;

  always #2 clk = ~clk;

  flash_prog_seq #(.BURST(BURST), .WIN_BYTES(WIN), .IMAGE_BYTES(IMG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_mode_i(byte_mode),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready_o),
    .vec_rd_o(vec_rd_o), .vec_word_i(vec_q), .ctrl_wr_o(ctrl_wr_o),
    .ctrl_set_o(ctrl_set_o), .ctrl_stat_i(ctrl_stat), .fl_wr_o(fl_wr_o),
    .fl_win_o(fl_win_o), .fl_off_o(fl_off_o), .fl_data_o(fl_data_o),
    .done_o(done_o), .sreset_o(sreset_o)
  );

  // Behavioural flash: bit-set control register, busy countdown, AND-programming.
  logic [7:0] fmem [0:IMG-1];
  logic [7:0] img  [0:IMG-1];
  logic [7:0] ctrl_q, pend_q;
  int busy_cnt;
  logic busy;
  assign busy      = (busy_cnt != 0);
  assign ctrl_stat = {ctrl_q[7:1], busy};

  always @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00; pend_q <= 8'h00; busy_cnt <= 0; vec_q <= 16'h0000;
    end else begin
      if (vec_rd_o) vec_q <= {fmem[0], fmem[1]};
      if (ctrl_wr_o) begin
        if (ctrl_set_o[7]) begin busy_cnt <= BUSY_CYC; pend_q <= ctrl_q; end
        else ctrl_q <= ctrl_q | ctrl_set_o;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) begin
          if (pend_q[5]) for (int k = 0; k < IMG; k++) fmem[k] = 8'hFF;
          ctrl_q <= 8'h00;
        end
      end
      if (fl_wr_o) begin
        int a;
        a = int'(fl_win_o) * WIN + int'(fl_off_o);
        if (a < IMG) fmem[a] = fmem[a] & fl_data_o;
      end
    end
  end

  int checks = 0, fails = 0;
  int done_cnt = 0, rise_cnt = 0;
  logic ready_prev = 1'b0;
  logic [31:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_item(input logic [7:0] c);
    return {8'h01, 16'h0000, c};
  endfunction

  function automatic logic [31:0] data_item(input int idx, input logic [7:0] d);
    return {8'h02, 8'(idx / WIN), 8'(idx % WIN), d};
  endfunction

  // Scoreboard monitor: pops expected items as the design issues them.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (ctrl_wr_o || fl_wr_o) begin
        logic [31:0] act, exp;
        string tag;
        act = ctrl_wr_o ? ctrl_item(ctrl_set_o) : {8'h02, 8'(fl_win_o), 8'(fl_off_o), fl_data_o};
        if (fl_wr_o) tag = "R7";
        else if (ctrl_set_o == 8'h20) tag = "R3";
        else if (ctrl_set_o == 8'h10) tag = "R6";
        else tag = "R5";
        if (busy) chk(1'b0, "R4", 32'(busy), 32'h0);
        if (exp_q.size() == 0) chk(1'b0, {tag, " unexpected"}, act, 32'h0);
        else begin
          exp = exp_q.pop_front();
          chk(act == exp, tag, act, exp);
        end
      end
      if (src_ready_o && !ready_prev) rise_cnt++;
      ready_prev = src_ready_o;
      if (done_o || sreset_o) begin
        chk(done_o && sreset_o, "R9", {31'h0, sreset_o}, {31'h0, done_o});
        chk(!busy, "R9", 32'(busy), 32'h0);
        chk(exp_q.size() == 0, "R8", 32'(exp_q.size()), 32'h0);
        done_cnt++;
      end
    end
  end

  task automatic run(input bit bmode, input bit do_erase, input int seed, input int gap);
    for (int i = 0; i < IMG; i++) img[i] = 8'((i * 29 + seed * 13) ^ (i >> 2));
    if (do_erase) begin
      exp_q.push_back(ctrl_item(8'h20));
      exp_q.push_back(ctrl_item(8'h80));
    end
    if (bmode) begin
      for (int i = 0; i < IMG; i++) begin
        exp_q.push_back(ctrl_item(8'h10));
        exp_q.push_back(data_item(i, img[i]));
        exp_q.push_back(ctrl_item(8'h80));
      end
    end else begin
      for (int b = 0; b < IMG / BURST; b++) begin
        exp_q.push_back(ctrl_item(8'h40));
        for (int j = 0; j < BURST; j++) exp_q.push_back(data_item(b * BURST + j, img[b * BURST + j]));
        exp_q.push_back(ctrl_item(8'h80));
      end
    end
    done_cnt = 0; rise_cnt = 0;
    @(negedge clk); start = 1'b1; byte_mode = bmode;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < IMG; i++) begin
      if (gap > 0) begin
        src_valid = 1'b0;
        repeat (i % gap) @(negedge clk);
      end
      src_valid = 1'b1; src_data = img[i];
      while (!src_ready_o) @(negedge clk);
      @(negedge clk);
    end
    src_valid = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 done count", 32'(done_cnt), 32'd1);
    if (bmode) chk(rise_cnt == IMG, "R6 ready strobes", 32'(rise_cnt), 32'(IMG));
  endtask

  task automatic check_image(input string tag);
    int bad = 0, first = -1;
    for (int k = 0; k < IMG; k++) if (fmem[k] !== img[k]) begin bad++; if (first < 0) first = k; end
    chk(bad == 0, tag, 32'(bad), 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < IMG; k++) fmem[k] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk({src_ready_o, vec_rd_o, ctrl_wr_o, fl_wr_o, done_o, sreset_o} == 6'b0, "R1 in reset",
        32'({src_ready_o, vec_rd_o, ctrl_wr_o, fl_wr_o, done_o, sreset_o}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({src_ready_o, vec_rd_o, ctrl_wr_o, fl_wr_o, done_o, sreset_o} == 6'b0, "R1 idle",
        32'({src_ready_o, vec_rd_o, ctrl_wr_o, fl_wr_o, done_o, sreset_o}), 32'h0);

    // R2: blank array, page style, no erase expected
    run(1'b0, 1'b0, 1, 0);
    check_image("R2 R8 blank page image");

    // R3: programmed vector forces erase, page style
    run(1'b0, 1'b1, 2, 0);
    check_image("R3 R8 erase page image");

    // R6 R10: byte style with stalls in the source stream, erase required
    run(1'b1, 1'b1, 3, 3);
    check_image("R6 R10 byte image");

    // R10: page style with gaps
    run(1'b0, 1'b1, 4, 4);
    check_image("R10 page gaps image");

    // R2: vector blank but body dirty -> erase skipped, so body ANDs with old zeros
    for (int k = 0; k < IMG; k++) fmem[k] = 8'h00;
    fmem[0] = 8'hFF; fmem[1] = 8'hFF;
    run(1'b0, 1'b0, 5, 0);
    chk(fmem[100] == 8'h00, "R2 erase skipped", 32'(fmem[100]), 32'h0);
    chk(fmem[0] == img[0], "R2 vector byte", 32'(fmem[0]), 32'(img[0]));

    summary();
    $finish;
  end

endmodule